// File: doc/BRIEF.md
# Interrupt Status and Control Register

This block is one 32-bit control and status word for a network controller. It latches two sticky event flags: a system-error flag and an excessive-deferral flag. It holds four control bits and drives a registered, level-sensitive interrupt line. Software clears a flag by writing 1 to its bit. A read followed by a write-back of the same value therefore acknowledges every pending event without touching the control bits.

The block also decides, at the end of each transmitted frame, whether the transmit-complete flag in a neighbouring register should be raised. The decision uses the frame's success status, a per-descriptor last-frame marker, a transmit-OK disable bit and an override bit that gives the marker control. The answer leaves the block as a one-cycle pulse.

There are two reset inputs. The hard reset is asynchronous and active low. The soft reset is synchronous and active high. They clear different sets of bits. A stop request is accepted but changes nothing in this register. The host port is a plain register port: reads are combinational and writes take effect at the clock edge, so no back-pressure exists. Any system-error strobe also produces a one-cycle stop pulse. The surrounding logic uses that pulse to drop its global interrupt enable.

Top module: `isr_ctrl_reg`

## Requirements
- R1: After the hard reset, the read data, the interrupt line, the transmit-complete pulse and the stop pulse are all 0.
- R2: Bits 15 (transmit-OK disable), 14 (marker override), 10 (system enable) and 6 (deferral enable) read back exactly what was last written. Bits 31-16, 13-12 and 9-8 ignore writes and always read 0.
- R3: Bit 11, the system flag, is set one cycle after a parity-error, master-abort or target-abort strobe. Setting it on a parity error depends on no other bit. Writing 1 to bit 11 clears it, and writing 0 leaves it set.
- R4: Bit 7, the deferral flag, is set one cycle after the excessive-deferral strobe. Writing 1 to bit 7 clears it, and writing 0 leaves it set.
- R5: If a set strobe and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R6: The soft reset clears bits 15, 14, 11 and 10, and it leaves bits 7 and 6 unchanged.
- R7: The stop request has no effect on any bit of the register or on the interrupt line.
- R8: When bit 14 is 0, a frame end raises the transmit-complete pulse one cycle later in two cases: the frame had an error, or bit 15 is 0. A successful frame with bit 15 at 1 raises nothing. With no frame end, there is no pulse.
- R9: When bit 14 is 1, bit 15 is ignored. A frame whose marker is 1 always raises the pulse. A frame whose marker is 0 raises it only on error.
- R10: The interrupt line is registered. One cycle after the flags change, it equals (bit 11 AND bit 10) OR (bit 7 AND bit 6 AND the global enable input). The system path does not depend on the global enable.
- R11: Any system-error strobe produces the stop pulse one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| hard_rst_n_i | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset, active high |
| stop_req_i | input | 1 | Stop request (no effect on this register) |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 32 | Host write data |
| rd_data_o | output | 32 | Host read data (combinational) |
| err_parity_i | input | 1 | Data parity error seen during a bus-master transfer |
| err_mabort_i | input | 1 | Master abort seen during a bus-master transfer |
| err_tabort_i | input | 1 | Target abort seen during a bus-master transfer |
| exc_defer_i | input | 1 | Excessive deferral on a transmit frame |
| tx_done_i | input | 1 | End of a transmitted frame |
| tx_ok_i | input | 1 | Frame status: 1 success, 0 error |
| tx_mark_i | input | 1 | Last-frame marker from the frame's descriptor |
| glob_irq_en_i | input | 1 | Global interrupt enable |
| tx_int_set_o | output | 1 | Pulse: raise the transmit-complete flag |
| sys_stop_o | output | 1 | Pulse: internal stop after a system error |
| irq_o | output | 1 | Level interrupt line |

## Verification
The hardest situation to reach from the ports is a hardware set strobe that lands in the same cycle as a host write-1 clear of the same flag. The bench first sets the flag. It then drives the error strobe and the clearing write in the same cycle, and checks that the flag is still set afterwards. The transmit decision and the interrupt combine are swept over every combination of their control and status inputs.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_CTL = 4;
  // control bit positions, in order: tx-ok disable, override, sys enable, defer enable
  localparam int unsigned CTL_POS  [NUM_CTL] = '{15, 14, 10, 6};
  // 1: soft reset clears the bit
  localparam bit          CTL_SOFT [NUM_CTL] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam int unsigned IDX_TXOK_DIS = 0;
  localparam int unsigned IDX_OVR      = 1;
  localparam int unsigned IDX_SYS_EN   = 2;
  localparam int unsigned IDX_EXD_EN   = 3;
  localparam int unsigned SYS_POS      = 11;
  localparam int unsigned EXD_POS      = 7;
endpackage

// File: rtl/isr_ctl_bit.sv
module isr_ctl_bit #(
  parameter bit SOFT_CLR = 1'b1
) (
  input  logic clk_i,
  input  logic hard_rst_n_i,
  input  logic soft_rst_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge hard_rst_n_i) begin
    if (!hard_rst_n_i)             q_o <= 1'b0;
    else if (SOFT_CLR && soft_rst_i) q_o <= 1'b0;
    else if (wr_en_i)              q_o <= wr_bit_i;
  end

  AST_CTL_WRITE: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (wr_en_i && !(SOFT_CLR && soft_rst_i)) |=> (q_o == $past(wr_bit_i))); // R2
endmodule

// File: rtl/isr_w1c_flag.sv
module isr_w1c_flag #(
  parameter bit SOFT_CLR = 1'b1
) (
  input  logic clk_i,
  input  logic hard_rst_n_i,
  input  logic soft_rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic soft_hit;
  assign soft_hit = SOFT_CLR && soft_rst_i;

  always_ff @(posedge clk_i or negedge hard_rst_n_i) begin
    if (!hard_rst_n_i)  q_o <= 1'b0;
    else if (soft_hit)  q_o <= 1'b0;
    else if (set_i)     q_o <= 1'b1;
    else if (clr_i)     q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (set_i && !soft_hit) |=> q_o); // R5
  AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (q_o && !clr_i && !soft_hit) |=> q_o); // R3
  AST_ONE_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (clr_i && !set_i) |=> !q_o); // R4
endmodule

// File: rtl/isr_tx_policy.sv
module isr_tx_policy (
  input  logic clk_i,
  input  logic hard_rst_n_i,
  input  logic tx_done_i,
  input  logic tx_ok_i,
  input  logic tx_mark_i,
  input  logic txok_dis_i,
  input  logic ovr_i,
  output logic tx_int_set_o
);
  logic raise;

  always_comb begin
    if (ovr_i) raise = tx_mark_i || !tx_ok_i;
    else       raise = !tx_ok_i || !txok_dis_i;
  end

  always_ff @(posedge clk_i or negedge hard_rst_n_i) begin
    if (!hard_rst_n_i) tx_int_set_o <= 1'b0;
    else               tx_int_set_o <= tx_done_i && raise;
  end

  AST_TX_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    !tx_done_i |=> !tx_int_set_o); // R8
  AST_TX_ERR_RAISES: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (tx_done_i && !tx_ok_i) |=> tx_int_set_o); // R8
  AST_TX_MARK_RAISES: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (tx_done_i && ovr_i && tx_mark_i) |=> tx_int_set_o); // R9
  AST_TX_OK_SUPPRESSED: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (tx_done_i && tx_ok_i && !tx_mark_i && (ovr_i || txok_dis_i)) |=> !tx_int_set_o); // R9
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen (
  input  logic clk_i,
  input  logic hard_rst_n_i,
  input  logic sys_flag_i,
  input  logic sys_en_i,
  input  logic exd_flag_i,
  input  logic exd_en_i,
  input  logic glob_en_i,
  output logic irq_o
);
  logic sys_pend, exd_pend;
  assign sys_pend = sys_flag_i && sys_en_i;
  assign exd_pend = exd_flag_i && exd_en_i && glob_en_i;

  always_ff @(posedge clk_i or negedge hard_rst_n_i) begin
    if (!hard_rst_n_i) irq_o <= 1'b0;
    else               irq_o <= sys_pend || exd_pend;
  end

  AST_SYS_IRQ_NO_GIE: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    sys_pend |=> irq_o); // R10
  AST_IRQ_DROPS: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (!sys_pend && !exd_pend) |=> !irq_o); // R10
endmodule

// File: rtl/isr_ctrl_reg.sv
module isr_ctrl_reg
  import isr_pkg::*;
(
  input  logic              clk_i,
  input  logic              hard_rst_n_i,
  input  logic              soft_rst_i,
  input  logic              stop_req_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              err_parity_i,
  input  logic              err_mabort_i,
  input  logic              err_tabort_i,
  input  logic              exc_defer_i,
  input  logic              tx_done_i,
  input  logic              tx_ok_i,
  input  logic              tx_mark_i,
  input  logic              glob_irq_en_i,
  output logic              tx_int_set_o,
  output logic              sys_stop_o,
  output logic              irq_o
);
  logic [NUM_CTL-1:0] ctl_q;
  logic               sys_q, exd_q, sys_err;

  assign sys_err = err_parity_i || err_mabort_i || err_tabort_i;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    isr_ctl_bit #(.SOFT_CLR(CTL_SOFT[g])) u_bit (
      .clk_i        (clk_i),
      .hard_rst_n_i (hard_rst_n_i),
      .soft_rst_i   (soft_rst_i),
      .wr_en_i      (wr_en_i),
      .wr_bit_i     (wr_data_i[CTL_POS[g]]),
      .q_o          (ctl_q[g])
    );
  end

  isr_w1c_flag #(.SOFT_CLR(1'b1)) u_sys_flag (
    .clk_i        (clk_i),
    .hard_rst_n_i (hard_rst_n_i),
    .soft_rst_i   (soft_rst_i),
    .set_i        (sys_err),
    .clr_i        (wr_en_i && wr_data_i[SYS_POS]),
    .q_o          (sys_q)
  );

  isr_w1c_flag #(.SOFT_CLR(1'b0)) u_exd_flag (
    .clk_i        (clk_i),
    .hard_rst_n_i (hard_rst_n_i),
    .soft_rst_i   (soft_rst_i),
    .set_i        (exc_defer_i),
    .clr_i        (wr_en_i && wr_data_i[EXD_POS]),
    .q_o          (exd_q)
  );

  isr_tx_policy u_tx (
    .clk_i        (clk_i),
    .hard_rst_n_i (hard_rst_n_i),
    .tx_done_i    (tx_done_i),
    .tx_ok_i      (tx_ok_i),
    .tx_mark_i    (tx_mark_i),
    .txok_dis_i   (ctl_q[IDX_TXOK_DIS]),
    .ovr_i        (ctl_q[IDX_OVR]),
    .tx_int_set_o (tx_int_set_o)
  );

  isr_irq_gen u_irq (
    .clk_i        (clk_i),
    .hard_rst_n_i (hard_rst_n_i),
    .sys_flag_i   (sys_q),
    .sys_en_i     (ctl_q[IDX_SYS_EN]),
    .exd_flag_i   (exd_q),
    .exd_en_i     (ctl_q[IDX_EXD_EN]),
    .glob_en_i    (glob_irq_en_i),
    .irq_o        (irq_o)
  );

  always_ff @(posedge clk_i or negedge hard_rst_n_i) begin
    if (!hard_rst_n_i) sys_stop_o <= 1'b0;
    else               sys_stop_o <= sys_err;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CTL; i++) rd_data_o[CTL_POS[i]] = ctl_q[i];
    rd_data_o[SYS_POS] = sys_q;
    rd_data_o[EXD_POS] = exd_q;
  end

  AST_STOP_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (stop_req_i && !wr_en_i && !soft_rst_i && !sys_err && !exc_defer_i) |=> $stable(rd_data_o)); // R7
  AST_SOFT_KEEPS_DEFER: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (soft_rst_i && !wr_en_i && !exc_defer_i) |=> (rd_data_o[EXD_POS] == $past(rd_data_o[EXD_POS]))); // R6
  AST_SYS_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    sys_err |=> sys_stop_o); // R11
  AST_SYS_FLAG_SET: assert property (@(posedge clk_i) disable iff (!hard_rst_n_i)
    (sys_err && !soft_rst_i) |=> rd_data_o[SYS_POS]); // R3
endmodule

// File: tb/tb_isr_ctrl_reg.sv
module tb_isr_ctrl_reg;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        hard_rst_n, soft_rst, stop_req, wr_en;
  logic [31:0] wr_data, rd_data;
  logic        err_parity, err_mabort, err_tabort, exc_defer;
  logic        tx_done, tx_ok, tx_mark, glob_en;
  logic        tx_int_set, sys_stop, irq;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_ctrl_reg dut (
    .clk_i(clk), .hard_rst_n_i(hard_rst_n), .soft_rst_i(soft_rst), .stop_req_i(stop_req),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .err_parity_i(err_parity), .err_mabort_i(err_mabort), .err_tabort_i(err_tabort),
    .exc_defer_i(exc_defer), .tx_done_i(tx_done), .tx_ok_i(tx_ok), .tx_mark_i(tx_mark),
    .glob_irq_en_i(glob_en), .tx_int_set_o(tx_int_set), .sys_stop_o(sys_stop), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [31:0] ctl_word(input int v);
    return {16'h0, v[3] ? 1'b1 : 1'b0, v[2] ? 1'b1 : 1'b0, 3'b0, v[1] ? 1'b1 : 1'b0,
            3'b0, v[0] ? 1'b1 : 1'b0, 6'b0};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    hard_rst_n = 1'b0; soft_rst = 0; stop_req = 0; wr_en = 0; wr_data = '0;
    err_parity = 0; err_mabort = 0; err_tabort = 0; exc_defer = 0;
    tx_done = 0; tx_ok = 0; tx_mark = 0; glob_en = 0;
    repeat (3) step();
    hard_rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_int_set", {31'h0, tx_int_set}, 32'h0);
    chk("R1 sys_stop", {31'h0, sys_stop}, 32'h0);

    // R2 sweep of control bits with reserved bits written as 1
    for (int v = 0; v < 16; v++) begin
      logic [31:0] cw;
      cw = ctl_word(v);
      wr(cw | 32'hFFFF_3300);
      chk("R2 control readback", rd_data, cw);
    end

    // R8 / R9 sweep: {disable, override, marker, ok}
    for (int v = 0; v < 16; v++) begin
      logic dis, ovr, mk, ok, exp_raise;
      dis = v[3]; ovr = v[2]; mk = v[1]; ok = v[0];
      wr({16'h0, dis, ovr, 14'h0});
      tx_done = 1'b1; tx_mark = mk; tx_ok = ok;
      step();
      tx_done = 1'b0;
      exp_raise = ovr ? (mk | ~ok) : (~ok | ~dis);
      chk(ovr ? "R9 tx policy" : "R8 tx policy", {31'h0, tx_int_set}, {31'h0, exp_raise});
      step();
      chk("R8 pulse ends", {31'h0, tx_int_set}, 32'h0);
    end

    // R3 / R11 each system error source
    wr(32'h0);
    for (int k = 0; k < 3; k++) begin
      err_parity = (k == 0); err_mabort = (k == 1); err_tabort = (k == 2);
      step();
      err_parity = 0; err_mabort = 0; err_tabort = 0;
      chk("R3 sys flag set", rd_data, 32'h0000_0800);
      chk("R11 stop pulse", {31'h0, sys_stop}, 32'h1);
      wr(32'h0);
      chk("R3 zero write keeps", rd_data, 32'h0000_0800);
      wr(32'h0000_0800);
      chk("R3 one write clears", rd_data, 32'h0);
    end

    // R4 deferral flag
    exc_defer = 1'b1; step(); exc_defer = 1'b0;
    chk("R4 defer flag set", rd_data, 32'h0000_0080);
    wr(32'h0);
    chk("R4 zero write keeps", rd_data, 32'h0000_0080);
    wr(32'h0000_0080);
    chk("R4 one write clears", rd_data, 32'h0);

    // R5 set beats clear in the same cycle
    err_mabort = 1'b1; exc_defer = 1'b1; step(); err_mabort = 0; exc_defer = 0;
    err_parity = 1'b1; exc_defer = 1'b1;
    wr(32'h0000_0880);
    err_parity = 0; exc_defer = 0;
    chk("R5 set wins", rd_data, 32'h0000_0880);
    wr(32'h0000_0880);
    chk("R5 later clear", rd_data, 32'h0);

    // R10 sweep of {sys enable, defer enable, global enable}
    for (int v = 0; v < 8; v++) begin
      logic se, de, ge, exp_irq;
      logic [31:0] en;
      se = v[2]; de = v[1]; ge = v[0];
      en = {21'h0, se, 3'h0, de, 6'h0};
      glob_en = ge;
      wr(en);
      err_tabort = 1'b1; exc_defer = 1'b1; step(); err_tabort = 0; exc_defer = 0;
      exp_irq = se | (de & ge);
      chk("R10 irq latency", {31'h0, irq}, 32'h0);
      step();
      chk("R10 irq level", {31'h0, irq}, {31'h0, exp_irq});
      wr(en | 32'h0000_0880);
      chk("R10 irq held one cycle", {31'h0, irq}, {31'h0, exp_irq});
      step();
      chk("R10 irq drops", {31'h0, irq}, 32'h0);
    end

    // R6 soft reset
    wr(32'h0000_C440);
    err_parity = 1'b1; exc_defer = 1'b1; step(); err_parity = 0; exc_defer = 0;
    chk("R6 before soft", rd_data, 32'h0000_CCC0);
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    chk("R6 soft reset", rd_data, 32'h0000_00C0);

    // R7 stop request
    wr(32'h0000_C440);
    err_parity = 1'b1; step(); err_parity = 0;
    glob_en = 1'b1; step();
    stop_req = 1'b1;
    repeat (3) step();
    chk("R7 stop ignored rd", rd_data, 32'h0000_CCC0);
    chk("R7 stop ignored irq", {31'h0, irq}, 32'h1);
    stop_req = 1'b0;

    // R1 hard reset clears bits the soft reset keeps
    hard_rst_n = 1'b0; step(); hard_rst_n = 1'b1; step();
    chk("R1 hard reset", rd_data, 32'h0);
    chk("R1 hard reset irq", {31'h0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule